// File: doc/BRIEF.md
# Dual-Rail Two-Input Lookup Cell

This block is a configurable logic cell with two logical inputs and one logical output. Every logical bit travels on a pair of wires under a level encoding: a value rail that carries the data bit, and a parity rail. The XOR of the two rails is the token's phase. Consecutive tokens alternate phase, and no spacer token sits between them. A small truth table sets the cell's function. It is written through a configuration port.

The cell is idle while its output phase equals the phase of its inputs. When both inputs carry the same phase, and that phase differs from the output phase, a new operation is pending. At the next clock edge the output takes the selected table entry under the new phase, and the acknowledge toggles so upstream cells may send their next token. An input pair whose phases disagree is stopped by a phase decoder before table selection, so the previous output is held and no holding multiplexers are needed. The input count is a parameter that defaults to two.

Top module: `drlut_cell`

## Requirements
- R1: After reset, both output rails are 0 (value 0, phase 0), the acknowledge is 0, and the truth table holds the parameter RESET_TBL (default all zeros).
- R2: A token's phase is value rail XOR parity rail. After an evaluation, the output phase equals the input phase, and the parity rail equals the new value XOR that phase.
- R3: If all input phases are equal and differ from the output phase, the output value rail at the next clock edge equals table bit k, where k = {B value, A value} (op_v[0] is A, op_v[1] is B).
- R4: If the input phases disagree, the output rails and the acknowledge keep their values at the next edge.
- R5: If all input phases equal the output phase, the cell is idle, and changing the input values has no effect on the outputs.
- R6: The acknowledge toggles exactly once per completed evaluation, on the same edge as the output update.
- R7: A configuration write (cfg_we=1) in a cycle with no pending evaluation loads cfg_tbl into the table at the next edge. Later evaluations use it.
- R8: A configuration write in a cycle where an evaluation is pending is ignored. The table keeps its old contents for that evaluation and for later ones.
- R9: A new token may arrive every cycle with no spacer. Each token of opposite phase is evaluated on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Truth-table write enable |
| cfg_tbl | input | 2**N_IN | New truth-table contents, bit k selected by input index k |
| op_v | input | N_IN | Input value rails, bit 0 is A |
| op_p | input | N_IN | Input parity rails |
| y_v | output | 1 | Output value rail |
| y_p | output | 1 | Output parity rail |
| ack | output | 1 | Toggles once per completed evaluation |

## Verification
A wrong stored output phase shows up one edge later, in either of two ways. The cell may evaluate again on inputs that should leave it idle, which makes the acknowledge toggle unexpectedly. Or it may refuse a valid token, so the acknowledge stays still while the output rails go stale. A corrupted truth-table bit stays hidden until a token selects that entry, so the bench sweeps all four indices under several tables. A write that slips in during a pending evaluation only shows on the next token that selects a changed entry, so the bench sends that token right after the write.

// File: rtl/drlut_pkg.sv
package drlut_pkg;

   // one logical bit on two wires
   typedef struct packed {
      logic v;   // value rail
      logic p;   // parity rail
   } rail_pair_t;

   function automatic logic tok_phase(input rail_pair_t t);
      return t.v ^ t.p;
   endfunction

   function automatic rail_pair_t tok_make(input logic val, input logic ph);
      rail_pair_t t;
      t.v = val;
      t.p = val ^ ph;
      return t;
   endfunction

endpackage

// File: rtl/drlut_phase_dec.sv
module drlut_phase_dec #(
   parameter int N_IN = 2
) (
   input  logic [N_IN-1:0] op_v,
   input  logic [N_IN-1:0] op_p,
   input  logic            cur_ph,
   output logic            fire,
   output logic            new_ph,
   output logic [N_IN-1:0] sel_idx
);
   import drlut_pkg::*;

   logic [N_IN-1:0] ph;
   logic            agree;

   for (genvar i = 0; i < N_IN; i++) begin : g_ph
      rail_pair_t tk;
      assign tk    = '{v: op_v[i], p: op_p[i]};
      assign ph[i] = tok_phase(tk);
   end

   if (N_IN == 1) begin : g_single
      assign agree = 1'b1;
   end else if (N_IN == 2) begin : g_pair
      assign agree = ~(ph[0] ^ ph[1]);
   end else begin : g_wide
      assign agree = (&ph) | ~(|ph);
   end

   assign new_ph  = ph[0];
   assign fire    = agree & (ph[0] != cur_ph);
   // only phase-consistent combinations reach the selector
   assign sel_idx = fire ? op_v : '0;

endmodule

// File: rtl/drlut_table.sv
module drlut_table #(
   parameter int N_IN = 2,
   parameter int TBL_W = 1 << N_IN,
   parameter logic [TBL_W-1:0] RESET_TBL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [TBL_W-1:0] wr_data,
   input  logic             lock,
   input  logic [N_IN-1:0]  sel_idx,
   output logic             entry,
   output logic [TBL_W-1:0] tbl
);
   logic [TBL_W-1:0] tbl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tbl_q <= RESET_TBL;
      else if (wr_en && !lock)
         tbl_q <= wr_data;
   end

   assign entry = tbl_q[sel_idx];
   assign tbl   = tbl_q;

endmodule

// File: rtl/drlut_out_enc.sv
module drlut_out_enc (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic res_bit,
   input  logic res_ph,
   output logic cur_ph,
   output logic y_v,
   output logic y_p,
   output logic ack
);
   import drlut_pkg::*;

   logic       v_q, ph_q, ack_q;
   rail_pair_t tk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         ph_q  <= 1'b0;
         ack_q <= 1'b0;
      end else if (fire) begin
         v_q   <= res_bit;
         ph_q  <= res_ph;
         ack_q <= ~ack_q;
      end
   end

   assign tk     = tok_make(v_q, ph_q);
   assign y_v    = tk.v;
   assign y_p    = tk.p;
   assign cur_ph = ph_q;
   assign ack    = ack_q;

endmodule

// File: rtl/drlut_cell.sv
module drlut_cell #(
   parameter int N_IN = 2,
   parameter int TBL_W = 1 << N_IN,
   parameter logic [TBL_W-1:0] RESET_TBL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [TBL_W-1:0] cfg_tbl,
   input  logic [N_IN-1:0]  op_v,
   input  logic [N_IN-1:0]  op_p,
   output logic             y_v,
   output logic             y_p,
   output logic             ack
);
   if (N_IN < 1 || N_IN > 6) begin : g_bad_n
      $error("drlut_cell: N_IN out of range");
   end
   if (TBL_W != (1 << N_IN)) begin : g_bad_w
      $error("drlut_cell: TBL_W must equal 2**N_IN");
   end

   logic            fire, new_ph, cur_ph, entry;
   logic [N_IN-1:0] sel_idx;
   logic [TBL_W-1:0] tbl_q;

   drlut_phase_dec #(.N_IN(N_IN)) u_dec (
      .op_v(op_v), .op_p(op_p), .cur_ph(cur_ph),
      .fire(fire), .new_ph(new_ph), .sel_idx(sel_idx)
   );

   drlut_table #(.N_IN(N_IN), .TBL_W(TBL_W), .RESET_TBL(RESET_TBL)) u_tbl (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_tbl),
      .lock(fire), .sel_idx(sel_idx), .entry(entry), .tbl(tbl_q)
   );

   drlut_out_enc u_enc (
      .clk(clk), .rst_n(rst_n), .fire(fire), .res_bit(entry),
      .res_ph(new_ph), .cur_ph(cur_ph), .y_v(y_v), .y_p(y_p), .ack(ack)
   );

endmodule

// File: rtl/drlut_cell_chk.sv
module drlut_cell_chk #(
   parameter int N_IN = 2,
   parameter int TBL_W = 1 << N_IN
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [TBL_W-1:0] cfg_tbl,
   input logic [N_IN-1:0]  op_v,
   input logic [N_IN-1:0]  op_p,
   input logic             y_v,
   input logic             y_p,
   input logic             ack,
   input logic [TBL_W-1:0] tbl
);
   logic [N_IN-1:0] iph;
   logic agree, yph, pend, idle;

   assign iph   = op_v ^ op_p;
   assign agree = (iph == '0) || (iph == '1);
   assign yph   = y_v ^ y_p;
   assign pend  = agree && (iph[0] != yph);
   assign idle  = agree && (iph[0] == yph);

   // R4
   hold_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !agree |=> ($stable(y_v) && $stable(y_p) && $stable(ack)));
   // R5
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> ($stable(y_v) && $stable(y_p) && $stable(ack)));
   // R3
   table_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend |=> (y_v == $past(tbl[op_v])));
   // R2
   phase_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend |=> ((y_v ^ y_p) == $past(iph[0])));
   // R6
   ack_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend |=> (ack != $past(ack)));
   // R8
   cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && cfg_we) |=> $stable(tbl));
   // R7
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && cfg_we) |=> (tbl == $past(cfg_tbl)));

endmodule

bind drlut_cell drlut_cell_chk #(.N_IN(N_IN), .TBL_W(TBL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
   .op_v(op_v), .op_p(op_p), .y_v(y_v), .y_p(y_p), .ack(ack), .tbl(tbl_q)
);

// File: tb/sim_drlut_cell.sv
`timescale 1ns/1ps
module sim_drlut_cell;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_tbl = '0;
   logic [1:0] op_v = '0;
   logic [1:0] op_p = '0;
   logic       y_v, y_p, ack;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // reference state
   int m_v = 0, m_ph = 0, m_ack = 0;
   int m_tbl = 0;

   always #2 clk = ~clk;

   drlut_cell u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
      .op_v(op_v), .op_p(op_p), .y_v(y_v), .y_p(y_p), .ack(ack)
   );

   task automatic compare(input string req);
      int ev, ep;
      ev = m_v;
      ep = m_v ^ m_ph;
      total++;
      if (y_v !== ev[0] || y_p !== ep[0] || ack !== m_ack[0]) begin
         bad++;
         $display("FAIL %s: got v=%0b p=%0b ack=%0b exp v=%0d p=%0d ack=%0d",
                  req, y_v, y_p, ack, ev, ep, m_ack);
      end
   endtask

   // drive one cycle at a falling edge, predict, check at the next falling edge
   task automatic step(input int av, input int aph, input int bv, input int bph,
                       input int we, input int cfg, input string req);
      int idx;
      op_v    = {bv[0], av[0]};
      op_p    = {bv[0] ^ bph[0], av[0] ^ aph[0]};
      cfg_we  = we[0];
      cfg_tbl = cfg[3:0];
      idx = bv * 2 + av;
      if (aph == bph && aph != m_ph) begin
         m_v   = (m_tbl >> idx) & 1;
         m_ph  = aph;
         m_ack = m_ack ^ 1;
      end else if (we != 0) begin
         m_tbl = cfg;
      end
      @(posedge clk);
      @(negedge clk);
      compare(req);
   endtask

   initial begin
      int ph;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 reset state");
      // reset table is all zero: a token with index 3 yields 0
      step(1, 1, 1, 1, 0, 0, "R1 reset table");
      // back to phase 0 idle-equivalent: send token phase 0
      step(0, 0, 0, 0, 0, 0, "R9 phase return");
      // load AND table while idle
      step(0, 0, 0, 0, 1, 4'b1000, "R7 cfg load");
      step(1, 1, 1, 1, 0, 0, "R3 and 11");
      step(0, 1, 1, 1, 0, 0, "R5 idle value change");
      step(0, 1, 0, 1, 0, 0, "R5 idle value change 2");
      step(1, 0, 0, 1, 0, 0, "R4 phase mismatch");
      step(0, 1, 1, 0, 0, 0, "R4 phase mismatch 2");
      step(1, 0, 0, 0, 0, 0, "R3 and 01");
      // XOR table, then back-to-back tokens over every index
      step(0, 0, 0, 0, 1, 4'b0110, "R7 cfg xor");
      ph = 1;
      for (int k = 0; k < 8; k++) begin
         step(k & 1, ph, (k >> 1) & 1, ph, 0, 0, "R9 back to back");
         ph ^= 1;
      end
      // write during a pending token is dropped
      step(1, ph, 0, ph, 1, 4'b1111, "R8 write while pending");
      ph ^= 1;
      step(1, ph, 1, ph, 0, 0, "R8 old table kept");
      ph ^= 1;
      step(0, ph, 0, ph, 0, 0, "R8 old table kept 2");
      // OR table through every index, mismatches between
      step(0, ph, 0, ph, 1, 4'b1110, "R7 cfg or");
      for (int k = 0; k < 4; k++) begin
         ph ^= 1;
         step(k & 1, ph, (k >> 1) & 1, ph ^ 1, 0, 0, "R4 mismatch sweep");
         step(k & 1, ph, (k >> 1) & 1, ph, 0, 0, "R3 or sweep");
         step((k & 1) ^ 1, ph, (k >> 1) & 1, ph, 0, 0, "R6 no second ack");
      end
      step(0, ph, 0, ph, 0, 0, "R2 final idle");
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #20000;
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: got hung exp finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule